// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block follows a chain of transfer descriptors in memory and fills a DMA channel's working parameters from each one. A start command gives it a descriptor pointer, a layout code and two update flags. It then reads the descriptor one 32-bit word at a time over a request/response memory port. When the last word of the descriptor has arrived, it presents the transfer parameters to a data mover. It holds them steady until the mover pulses completion.

Each descriptor starts with a link word, which is the address of the following descriptor, and then a control word. The control word carries the transfer length. It also carries the settings for the next descriptor: a continue flag, the source and destination update flags, and a two-bit layout code. These settings decide whether the walk goes on and how the next descriptor is read. The four layouts hold 3, 4, 5 or 9 words. The smallest one carries a single address that goes to whichever side is flagged for update. The rest carry a source and a destination address, and the larger ones add further transfer settings.

A read that returns an error ends the walk. The block then raises a sticky fault flag and goes back to idle.

Top module: `ll_desc_fetch`

## Requirements
- R1: After reset the block is idle: `busy`, `fault`, `rd_req` and `xfer_valid` are all low. A `go` pulse seen while idle loads `go_ptr`, `go_view`, `go_src_upd` and `go_dst_upd`, clears `fault` and starts fetching on the next cycle. A `go` pulse seen while busy has no effect.
- R2: Descriptor word k is read from byte address (pointer with bits 1:0 forced to zero) + 4*k, for k counting up from 0. `rd_req` stays high with `rd_addr` unchanged until `rd_valid` answers it, and there is never more than one read in flight.
- R3: The layout code sets the descriptor length: code 0 is 3 words, code 1 is 4, code 2 is 5 and code 3 is 9.
- R4: Word 0 is the link to the next descriptor and word 1 is the control word. Bits 23:0 of the control word appear unchanged on `xfer_len`. For codes 1 to 3, word 2 is the source address and word 3 is the destination address. For codes 2 and 3, word 4 is the configuration word. For code 3, words 5 to 8 are, in this order: block control, data stride, source stride and destination stride.
- R5: A source word is taken only when the source update flag of the current descriptor is set; otherwise the source register keeps its value. The destination word follows the same rule with its own flag.
- R6: In a code-0 descriptor, word 2 is written to the source register if the source flag is set and to the destination register if the destination flag is set. If neither flag is set, word 2 is dropped.
- R7: Once the last word of a descriptor has arrived, `xfer_valid` rises and every `xfer_*` output stays constant until `xfer_done` is seen. An `xfer_done` pulse at any other time has no effect.
- R8: When `xfer_done` arrives and bit 24 of the current control word is set, fetching resumes at the link address. The next descriptor then uses that control word's bits 28:27 as its layout code, bit 25 as its source flag and bit 26 as its destination flag. If bit 24 is clear, the block returns to idle.
- R9: A response with `rd_err` high ends the fetch. `fault` is then set and the block goes idle. `fault` stays set until the next accepted `go`. Words accepted before the error keep their effect.
- R10: Configuration, block control and stride registers that a descriptor's layout does not carry keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse for a new chain |
| go_ptr | input | AW | Byte address of the first descriptor |
| go_view | input | 2 | Layout code of the first descriptor |
| go_src_upd | input | 1 | Source update flag for the first descriptor |
| go_dst_upd | input | 1 | Destination update flag for the first descriptor |
| rd_req | output | 1 | Word read request, held until answered |
| rd_addr | output | AW | Byte address of the requested word |
| rd_valid | input | 1 | Response strobe for the pending read |
| rd_data | input | 32 | Response data |
| rd_err | input | 1 | Response carries an error |
| xfer_valid | output | 1 | Transfer parameters are loaded and presented |
| xfer_len | output | 24 | Microblock length in data units |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_cfg | output | 32 | Configuration word |
| xfer_bc | output | 32 | Block control word |
| xfer_ds | output | 32 | Data stride |
| xfer_sus | output | 32 | Source microblock stride |
| xfer_dus | output | 32 | Destination microblock stride |
| xfer_done | input | 1 | Completion pulse from the data mover |
| busy | output | 1 | Fetching or presenting a transfer |
| fault | output | 1 | Sticky read-error flag |

## Verification
The assertions assume the memory side answers only while `rd_req` is high and returns exactly one one-cycle `rd_valid` per request. They also assume that `go` and `xfer_done` are single-cycle pulses. The bench responder keeps to these rules by design. It counts a configurable latency while a request is pending, answers once, and drops the strobe on the next cycle. The mover model raises `xfer_done` only while `xfer_valid` is high. The one exception is a single deliberate pulse while idle, and no property depends on that cycle.

// File: rtl/ll_desc_fetch.sv
module ll_desc_fetch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_ptr,
  input  logic [1:0]    go_view,
  input  logic          go_src_upd,
  input  logic          go_dst_upd,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  input  logic          rd_err,
  output logic          xfer_valid,
  output logic [23:0]   xfer_len,
  output logic [31:0]   xfer_src,
  output logic [31:0]   xfer_dst,
  output logic [31:0]   xfer_cfg,
  output logic [31:0]   xfer_bc,
  output logic [31:0]   xfer_ds,
  output logic [31:0]   xfer_sus,
  output logic [31:0]   xfer_dus,
  input  logic          xfer_done,
  output logic          busy,
  output logic          fault
);

  localparam int CW = 4;
  localparam int FETCH_BIT = 24;
  localparam int SRC_BIT = 25;
  localparam int DST_BIT = 26;
  localparam int VIEW_LO = 27;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN} state_t;

  state_t        st;
  logic [AW-1:0] ptr, nxt;
  logic [1:0]    view;
  logic          sen, den;
  logic [CW-1:0] cnt, last;
  logic [31:0]   ctl;
  logic          take;

  always_comb begin
    case (view)
      2'd0:    last = CW'(2);
      2'd1:    last = CW'(3);
      2'd2:    last = CW'(4);
      default: last = CW'(8);
    endcase
  end

  assign take       = (st == S_FETCH) && rd_valid;
  assign rd_req     = (st == S_FETCH);
  assign rd_addr    = {ptr[AW-1:2], 2'b00} + AW'({cnt, 2'b00});
  assign xfer_valid = (st == S_RUN);
  assign busy       = (st != S_IDLE);
  assign xfer_len   = ctl[23:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      view  <= '0;
      sen   <= 1'b0;
      den   <= 1'b0;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st    <= S_FETCH;
          ptr   <= go_ptr;
          view  <= go_view;
          sen   <= go_src_upd;
          den   <= go_dst_upd;
          cnt   <= '0;
          fault <= 1'b0;
        end
        S_FETCH: if (rd_valid) begin
          if (rd_err) begin
            st    <= S_IDLE;
            fault <= 1'b1;
            cnt   <= '0;
          end else if (cnt == last) begin
            st  <= S_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RUN: if (xfer_done) begin
          if (ctl[FETCH_BIT]) begin
            st   <= S_FETCH;
            ptr  <= nxt;
            view <= ctl[VIEW_LO+1:VIEW_LO];
            sen  <= ctl[SRC_BIT];
            den  <= ctl[DST_BIT];
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt      <= '0;
      ctl      <= '0;
      xfer_src <= '0;
      xfer_dst <= '0;
      xfer_cfg <= '0;
      xfer_bc  <= '0;
      xfer_ds  <= '0;
      xfer_sus <= '0;
      xfer_dus <= '0;
    end else if (take && !rd_err) begin
      case (cnt)
        CW'(0): nxt <= rd_data[AW-1:0];
        CW'(1): ctl <= rd_data;
        CW'(2): begin
          if (sen) xfer_src <= rd_data;
          if (view == 2'd0 && den) xfer_dst <= rd_data;
        end
        CW'(3): if (den) xfer_dst <= rd_data;
        CW'(4): xfer_cfg <= rd_data;
        CW'(5): xfer_bc  <= rd_data;
        CW'(6): xfer_ds  <= rd_data;
        CW'(7): xfer_sus <= rd_data;
        CW'(8): xfer_dus <= rd_data;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ll_desc_fetch_chk.sv
module ll_desc_fetch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          rd_err,
  input logic          xfer_valid,
  input logic [23:0]   xfer_len,
  input logic [31:0]   xfer_src,
  input logic [31:0]   xfer_dst,
  input logic [31:0]   xfer_cfg,
  input logic          xfer_done,
  input logic          busy,
  input logic          fault
);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  assert_params_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_len) && $stable(xfer_src)
                                 && $stable(xfer_dst) && $stable(xfer_cfg));

  assert_done_leaves_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && xfer_done |=> !xfer_valid);

  assert_err_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid && rd_err |=> !busy && fault);

  assert_go_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go |=> busy && rd_req && !fault);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !(go && !busy) |=> fault);

endmodule

bind ll_desc_fetch ll_desc_fetch_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_ll_desc_fetch.sv
module test_ll_desc_fetch;
  localparam int PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [AW-1:0] go_ptr = '0;
  logic [1:0] go_view = '0;
  logic go_src_upd = 1'b0, go_dst_upd = 1'b0;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic rd_err = 1'b0;
  logic xfer_valid;
  logic [23:0] xfer_len;
  logic [31:0] xfer_src, xfer_dst, xfer_cfg, xfer_bc, xfer_ds, xfer_sus, xfer_dus;
  logic xfer_done = 1'b0;
  logic busy, fault;

  ll_desc_fetch #(.AW(AW)) i_ll_desc_fetch (.*);

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors = 0;

  logic [31:0] mem [0:255];
  int lat = 1, rcnt = 0;
  int dlat = 2, dcnt = 0;
  bit kick = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_valid = 1'b0; rd_err = 1'b0; rcnt = 0;
    end else if (rd_valid) begin
      rd_valid = 1'b0; rd_err = 1'b0; rcnt = 0;
    end else if (rd_req) begin
      if (rcnt >= lat) begin
        rd_valid = 1'b1;
        rd_data  = mem[(rd_addr >> 2) & 255];
        rd_err   = (rd_addr == err_addr);
      end else rcnt++;
    end else rcnt = 0;
  end

  // data mover
  always @(negedge clk) begin
    if (!rst_n) begin
      xfer_done = 1'b0; dcnt = 0;
    end else if (xfer_done) begin
      xfer_done = 1'b0;
    end else if (kick) begin
      xfer_done = 1'b1; kick = 1'b0;
    end else if (xfer_valid) begin
      if (dcnt >= dlat) begin xfer_done = 1'b1; dcnt = 0; end
      else dcnt++;
    end
  end

  // behavioural reference model
  int m_st = 0, m_k = 0, m_view = 0;
  bit m_sen = 0, m_den = 0, m_fault = 0;
  logic [31:0] m_ptr = 0, m_nxt = 0, m_ctl = 0, m_src = 0, m_dst = 0;
  logic [31:0] m_opt [0:4];

  function automatic int words_of(int v);
    if (v == 0) return 3;
    if (v == 1) return 4;
    if (v == 2) return 5;
    return 9;
  endfunction

  task automatic m_word(int k, logic [31:0] d);
    if (k == 0) m_nxt = d;
    else if (k == 1) m_ctl = d;
    else if (k == 2) begin
      if (m_sen) m_src = d;
      if (m_view == 0 && m_den) m_dst = d;
    end else if (k == 3) begin
      if (m_den) m_dst = d;
    end else m_opt[k-4] = d;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_k = 0; m_view = 0; m_sen = 0; m_den = 0; m_fault = 0;
      m_ptr = 0; m_nxt = 0; m_ctl = 0; m_src = 0; m_dst = 0;
      for (int i = 0; i < 5; i++) m_opt[i] = 0;
    end else begin
      if (m_st == 0) begin
        if (go) begin
          m_ptr = go_ptr; m_view = int'(go_view); m_sen = go_src_upd; m_den = go_dst_upd;
          m_k = 0; m_fault = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (rd_valid) begin
          if (rd_err) begin
            m_fault = 1; m_st = 0; m_k = 0;
          end else begin
            m_word(m_k, rd_data);
            if (m_k == words_of(m_view) - 1) begin m_st = 2; m_k = 0; end
            else m_k++;
          end
        end
      end else if (xfer_done) begin
        if (m_ctl[24]) begin
          m_ptr = m_nxt; m_view = int'(m_ctl[28:27]);
          m_sen = m_ctl[25]; m_den = m_ctl[26]; m_st = 1;
        end else m_st = 0;
      end
    end
    #1;
    if (rst_n) begin
      chk(busy == (m_st != 0), "R1 busy", busy, m_st != 0);
      chk(fault == m_fault, "R9 fault", fault, m_fault);
      chk(rd_req == (m_st == 1), "R3 rd_req", rd_req, m_st == 1);
      if (m_st == 1)
        chk(rd_addr == (m_ptr & 32'hFFFF_FFFC) + 32'(4 * m_k), "R2 rd_addr",
            rd_addr, (m_ptr & 32'hFFFF_FFFC) + 32'(4 * m_k));
      chk(xfer_valid == (m_st == 2), "R7 xfer_valid", xfer_valid, m_st == 2);
      if (m_st == 2) begin
        chk(xfer_len == m_ctl[23:0], "R4 xfer_len", xfer_len, m_ctl[23:0]);
        chk(xfer_src == m_src, "R5 xfer_src", xfer_src, m_src);
        chk(xfer_dst == m_dst, "R5 xfer_dst", xfer_dst, m_dst);
        chk(xfer_cfg == m_opt[0], "R10 xfer_cfg", xfer_cfg, m_opt[0]);
        chk(xfer_bc == m_opt[1], "R10 xfer_bc", xfer_bc, m_opt[1]);
        chk(xfer_ds == m_opt[2], "R4 xfer_ds", xfer_ds, m_opt[2]);
        chk(xfer_sus == m_opt[3], "R4 xfer_sus", xfer_sus, m_opt[3]);
        chk(xfer_dus == m_opt[4], "R4 xfer_dus", xfer_dus, m_opt[4]);
      end
    end
  end

  task automatic start(logic [31:0] p, logic [1:0] v, bit s, bit d);
    @(negedge clk);
    go = 1'b1; go_ptr = p; go_view = v; go_src_upd = s; go_dst_upd = d;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic expect_run(string req, logic [23:0] len, logic [31:0] src, logic [31:0] dst,
                            logic [31:0] cfg, logic [31:0] bc);
    int n = 0;
    while (!xfer_valid && n < 500) begin @(negedge clk); n++; end
    chk(xfer_valid, {req, " run reached"}, xfer_valid, 1);
    chk(xfer_len == len, {req, " len"}, xfer_len, len);
    chk(xfer_src == src, {req, " src"}, xfer_src, src);
    chk(xfer_dst == dst, {req, " dst"}, xfer_dst, dst);
    chk(xfer_cfg == cfg, {req, " cfg"}, xfer_cfg, cfg);
    chk(xfer_bc == bc, {req, " bc"}, xfer_bc, bc);
    while (xfer_valid) @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        chk(1'b0, "watchdog", wd, 100000);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // D1 @0x40, layout 3
    mem[16] = 32'h80; mem[17] = 32'h0F00_0010; mem[18] = 32'h1000; mem[19] = 32'h2000;
    mem[20] = 32'hC0; mem[21] = 32'hB0; mem[22] = 32'hD0; mem[23] = 32'h51; mem[24] = 32'hD1;
    // D2 @0x80, layout 1
    mem[32] = 32'hC0; mem[33] = 32'h0300_0020; mem[34] = 32'h1100; mem[35] = 32'h2100;
    // D3 @0xC0, layout 0, source only
    mem[48] = 32'h100; mem[49] = 32'h1500_0030; mem[50] = 32'h1200;
    // D4 @0x100, layout 2, destination only, last
    mem[64] = 32'h0; mem[65] = 32'h0000_0040; mem[66] = 32'h9999; mem[67] = 32'h2300; mem[68] = 32'hC4;
    // @0x140, layout 0, no flags
    mem[80] = 32'h0; mem[81] = 32'h0000_0005; mem[82] = 32'hDEAD;
    // @0x180, layout 3, read error on word 2
    mem[96] = 32'h0; mem[97] = 32'h0000_0007; mem[98] = 32'hAAAA; mem[99] = 32'hBBBB;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !fault && !rd_req && !xfer_valid, "R1 reset state",
        {busy, fault, rd_req, xfer_valid}, 0);

    lat = 1; dlat = 2;
    start(32'h40, 2'd3, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    go = 1'b1; go_ptr = 32'h200; go_view = 2'd0;
    @(negedge clk);
    go = 1'b0;
    expect_run("R3 R4 nine-word", 24'h10, 32'h1000, 32'h2000, 32'hC0, 32'hB0);
    expect_run("R8 R10 four-word", 24'h20, 32'h1100, 32'h2100, 32'hC0, 32'hB0);
    expect_run("R6 single-address src", 24'h30, 32'h1200, 32'h2100, 32'hC0, 32'hB0);
    expect_run("R5 R10 five-word", 24'h40, 32'h1200, 32'h2300, 32'hC4, 32'hB0);
    wait_idle();
    chk(!busy, "R8 chain end idle", busy, 0);

    kick = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !xfer_valid, "R7 stray done ignored", {busy, rd_req, xfer_valid}, 0);

    lat = 0; dlat = 0;
    start(32'h143, 2'd0, 1'b0, 1'b0);
    chk(rd_addr == 32'h140, "R2 aligned first address", rd_addr, 32'h140);
    expect_run("R6 no flags", 24'h5, 32'h1200, 32'h2300, 32'hC4, 32'hB0);
    wait_idle();

    lat = 2; dlat = 1; err_addr = 32'h188;
    start(32'h180, 2'd3, 1'b1, 1'b1);
    wait_idle();
    chk(fault && !busy && !xfer_valid, "R9 error halts", {fault, busy, xfer_valid}, 3'b100);
    repeat (3) @(negedge clk);
    chk(fault, "R9 fault sticky", fault, 1);
    err_addr = 32'hFFFF_FFF0;
    start(32'h140, 2'd0, 1'b0, 1'b0);
    chk(!fault && busy, "R9 go clears fault", {fault, busy}, 2'b01);
    expect_run("R9 R5 after error", 24'h5, 32'h1200, 32'h2300, 32'hC4, 32'hB0);
    wait_idle();
    repeat (3) @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule